// File: doc/BRIEF.md
# Artificial Trigger Ratio Sequencer

This block issues artificial triggers on a fixed millisecond grid while a run is active. Every trigger slot carries one of three trigger kinds: pedestal, internal light-pulser or external light-pulser. A packed 15-bit ratio word sets how many consecutive slots each kind takes. The kinds are always played in the same order, and the cycle then wraps. Each kind has its own enable bit in a settings byte, and a veto bit in the same byte drops artificial triggers.

A prescaler divides the system clock into a 1 ms tick, and an interval counter counts those ticks up to the programmed interval. A kind that is disabled, or whose count is zero, is passed over within the same slot, so it uses no interval time. If no kind is eligible, slots pass with no strobe. Each trigger appears as a one-cycle strobe together with a 2-bit kind code.

The control is a three-state machine:
- `ST_IDLE`: run is low, and all counters and the sequence position are cleared.
- `ST_COUNT`: the prescaler and the interval counter run.
- `ST_FIRE`: lasts one cycle, in which the strobe may be issued and the sequence position advances.

The transitions are:
- `ST_IDLE`→`ST_COUNT` when run is high.
- `ST_COUNT`→`ST_FIRE` on the tick that completes the interval.
- `ST_FIRE`→`ST_COUNT` while run stays high.
- `ST_COUNT` or `ST_FIRE`→`ST_IDLE` whenever run is low.

Top module: `trig_ratio_seq`

## Requirements
- R1: While reset is asserted, and afterwards while run is low, `trig_o` stays low.
- R2: With P clock cycles per millisecond and interval I, the k-th strobe after run rises is visible in the cycle that follows clock edge k·P·I. Edge 0 is the edge that first samples run high. An interval of 0 behaves as 1.
- R3: `trig_o` is high for exactly one cycle per trigger.
- R4: The ratio word gives the pedestal count in bits 14:10, the internal light-pulser count in bits 9:5 and the external light-pulser count in bits 4:0. Slots go to pedestal, then internal, then external, each for its count, and the cycle then repeats.
- R5: `trig_type_o` is 0 for pedestal, 1 for internal light-pulser and 2 for external light-pulser. It never reads 3 during a strobe.
- R6: Settings bits 6, 5 and 4 enable pedestal, internal and external respectively. A disabled kind, or a kind with count 0, is skipped within the same slot and uses no interval.
- R7: If every kind is disabled or has count 0, no strobes are issued.
- R8: When settings bit 1 (veto) is set during a slot's fire cycle, that slot issues no strobe, but the sequence still advances as if it had fired.
- R9: When run falls, strobes stop. The next rise of run restarts the interval timing and the sequence from the first pedestal slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Run active |
| settings_i | input | 8 | Bit 6/5/4 kind enables, bit 1 veto; other bits unused |
| interval_i | input | 10 | Slot interval in milliseconds (0 treated as 1) |
| ratio_i | input | 15 | Packed repeat counts, three 5-bit fields |
| trig_o | output | 1 | One-cycle artificial trigger strobe |
| trig_type_o | output | 2 | Kind of the current strobe |

## Verification
The ratio word is exercised with mixed counts (2,1,3), with equal counts, and with a zero pedestal count. Together these separate correct field decoding, correct repeat lengths and correct wrap order. Runs with the internal kind disabled, and with a zero count, show whether a skipped kind wrongly consumes an interval slot. Veto is applied to chosen slots so that the following kinds reveal whether the sequence advanced through the dropped slot. Back-to-back runs stopped partway through a repeat group show whether a restart returns to the first pedestal slot, and intervals of 0, 2, 3 and 7 ms check the spacing.

// File: rtl/trs_pkg.sv
package trs_pkg;
    localparam int NUM_KINDS = 3;

    typedef enum logic [1:0] {
        TK_PED = 2'd0,
        TK_LPI = 2'd1,
        TK_LPE = 2'd2
    } trig_kind_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/trs_ms_tick.sv
module trs_ms_tick #(
    parameter int CLK_PER_MS = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    output logic tick_o
);
    localparam int PW = (CLK_PER_MS > 2) ? $clog2(CLK_PER_MS) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (!enable_i)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end

    assign tick_o = enable_i && (div_q == LAST);
endmodule

// File: rtl/trs_kind_pick.sv
module trs_kind_pick
    import trs_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [NUM_KINDS*CNT_W-1:0] ratio_i,
    input  logic [NUM_KINDS-1:0]       enable_i,
    input  trig_kind_t                 pos_i,
    input  logic [CNT_W-1:0]           rep_i,
    output logic                       any_o,
    output trig_kind_t                 sel_o,
    output trig_kind_t                 next_pos_o,
    output logic [CNT_W-1:0]           next_rep_o
);
    logic [CNT_W-1:0] count_w [NUM_KINDS];
    logic [NUM_KINDS-1:0] ok_w;

    // Kind 0 sits in the most significant field.
    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_unpack
        assign count_w[g] = ratio_i[(NUM_KINDS-g)*CNT_W-1 -: CNT_W];
        assign ok_w[g]    = enable_i[g] && (count_w[g] != '0);
    end

    function automatic trig_kind_t succ(input trig_kind_t k);
        return (k == TK_LPE) ? TK_PED : trig_kind_t'(k + 2'd1);
    endfunction

    logic [CNT_W:0] base_w;

    always_comb begin
        trig_kind_t probe;
        any_o = 1'b0;
        sel_o = pos_i;
        probe = pos_i;
        for (int d = 0; d < NUM_KINDS; d++) begin
            if (!any_o && ok_w[probe]) begin
                any_o = 1'b1;
                sel_o = probe;
            end
            probe = succ(probe);
        end
        base_w = (sel_o == pos_i) ? {1'b0, rep_i} : '0;
        if (base_w + 1'b1 >= {1'b0, count_w[sel_o]}) begin
            next_pos_o = succ(sel_o);
            next_rep_o = '0;
        end else begin
            next_pos_o = sel_o;
            next_rep_o = base_w[CNT_W-1:0] + 1'b1;
        end
    end
endmodule

// File: rtl/trig_ratio_seq.sv
module trig_ratio_seq
    import trs_pkg::*;
#(
    parameter int CLK_PER_MS = 125000,
    parameter int IVL_W      = 10,
    parameter int CNT_W      = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       run_i,
    input  logic [7:0]                 settings_i,
    input  logic [IVL_W-1:0]           interval_i,
    input  logic [NUM_KINDS*CNT_W-1:0] ratio_i,
    output logic                       trig_o,
    output logic [1:0]                 trig_type_o
);
    localparam int EN_PED_BIT = 6;
    localparam int VETO_BIT   = 1;

    seq_state_t       state_q, state_d;
    logic [IVL_W-1:0] ivl_q;
    trig_kind_t       pos_q, next_pos_w, sel_w;
    logic [CNT_W-1:0] rep_q, next_rep_w;
    logic             tick_w, any_w, slot_done_w;
    logic [IVL_W-1:0] ivl_eff_w;
    logic [NUM_KINDS-1:0] en_w;
    logic             unused_settings;

    assign unused_settings = ^{settings_i[7], settings_i[3:2], settings_i[0]};

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_en
        assign en_w[g] = settings_i[EN_PED_BIT-g];
    end

    assign ivl_eff_w   = (interval_i == '0) ? IVL_W'(1) : interval_i;
    assign slot_done_w = tick_w && ({1'b0, ivl_q} + 1'b1 >= {1'b0, ivl_eff_w});

    trs_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (state_q != ST_IDLE),
        .tick_o   (tick_w)
    );

    trs_kind_pick #(.CNT_W(CNT_W)) u_pick (
        .ratio_i    (ratio_i),
        .enable_i   (en_w),
        .pos_i      (pos_q),
        .rep_i      (rep_q),
        .any_o      (any_w),
        .sel_o      (sel_w),
        .next_pos_o (next_pos_w),
        .next_rep_o (next_rep_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (run_i) state_d = ST_COUNT;
            ST_COUNT: if (!run_i) state_d = ST_IDLE;
                      else if (slot_done_w) state_d = ST_FIRE;
            ST_FIRE:  state_d = run_i ? ST_COUNT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register plus the counters it owns.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ivl_q   <= '0;
            pos_q   <= TK_PED;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                ivl_q <= '0;
                pos_q <= TK_PED;
                rep_q <= '0;
            end else begin
                if (slot_done_w)
                    ivl_q <= '0;
                else if (tick_w)
                    ivl_q <= ivl_q + 1'b1;
                if (state_q == ST_FIRE && any_w) begin
                    pos_q <= next_pos_w;
                    rep_q <= next_rep_w;
                end
            end
        end
    end

    always_comb begin
        trig_o      = 1'b0;
        trig_type_o = sel_w;
        unique case (state_q)
            ST_FIRE:  trig_o = any_w && !settings_i[VETO_BIT];
            ST_IDLE,
            ST_COUNT: trig_o = 1'b0;
            default:  trig_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/trs_checker.sv
module trs_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        run_i,
    input logic [7:0]  settings_i,
    input logic [14:0] ratio_i,
    input logic        trig_o,
    input logic [1:0]  trig_type_o
);
    a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> !trig_o);

    a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    a_r5_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (trig_type_o != 2'd3));

    a_r6_kind_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((trig_type_o == 2'd0 && settings_i[6]) ||
                    (trig_type_o == 2'd1 && settings_i[5]) ||
                    (trig_type_o == 2'd2 && settings_i[4])));

    a_r6_nonzero_count: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((trig_type_o == 2'd0 && ratio_i[14:10] != 5'd0) ||
                    (trig_type_o == 2'd1 && ratio_i[9:5]   != 5'd0) ||
                    (trig_type_o == 2'd2 && ratio_i[4:0]   != 5'd0)));

    a_r8_veto_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        settings_i[1] |-> !trig_o);

    a_r9_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run_i) |-> !trig_o);
endmodule

bind trig_ratio_seq trs_checker u_trs_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .settings_i  (settings_i),
    .ratio_i     (ratio_i),
    .trig_o      (trig_o),
    .trig_type_o (trig_type_o)
);

// File: tb/trig_ratio_seq_tb_top.sv
module trig_ratio_seq_tb_top;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  settings = 8'h00;
    logic [9:0]  ivl = 10'd0;
    logic [14:0] ratio = 15'd0;
    logic        trig;
    logic [1:0]  typ;

    trig_ratio_seq #(.CLK_PER_MS(P)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .settings_i  (settings),
        .interval_i  (ivl),
        .ratio_i     (ratio),
        .trig_o      (trig),
        .trig_type_o (typ)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    n_chk = 0, n_fail = 0, n_seen = 0;
    int    exp_cyc[$];
    int    exp_typ[$];
    string cur_req = "R1";
    logic  prev_trig = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every strobe.
    always @(negedge clk) begin : mon
        int e, t;
        if (rst_n) begin
            if (trig) begin
                n_seen++;
                check(!prev_trig, "R3", "strobe width", 1, 0);
                if (exp_cyc.size() == 0) begin
                    check(0, cur_req, "unexpected strobe at cycle", cyc, -1);
                end else begin
                    e = exp_cyc.pop_front();
                    t = exp_typ.pop_front();
                    check(cyc == e, cur_req, "strobe cycle", cyc, e);
                    check(int'(typ) == t, cur_req, "kind code (R5)", int'(typ), t);
                end
            end
            prev_trig = trig;
        end
    end

    // Driver: models the expected slots and pushes them, then steps the run.
    task automatic run_case(input int iv, input int sq, input int st,
                            input int n, input int vmask, input string req);
        int c0, pi, pos, rep, sel, base, seen0, pushed;
        int cnt[3];
        bit en[3];
        bit found;
        cur_req  = req;
        settings = st[7:0];
        ivl      = iv[9:0];
        ratio    = sq[14:0];
        cnt[0] = (sq >> 10) & 31;
        cnt[1] = (sq >> 5) & 31;
        cnt[2] = sq & 31;
        for (int t = 0; t < 3; t++) en[t] = ((st >> (6 - t)) & 1) != 0;
        pi = P * ((iv == 0) ? 1 : iv);
        @(negedge clk);
        run = 1'b1;
        settings[1] = vmask[0];
        @(negedge clk);
        c0 = cyc;
        seen0 = n_seen;
        pos = 0; rep = 0; pushed = 0;
        for (int k = 1; k <= n; k++) begin
            found = 0; sel = pos;
            for (int d = 0; d < 3; d++) begin
                if (!found && en[(pos + d) % 3] && cnt[(pos + d) % 3] != 0) begin
                    found = 1;
                    sel = (pos + d) % 3;
                end
            end
            if (found) begin
                base = (sel == pos) ? rep : 0;
                if (base + 1 >= cnt[sel]) begin pos = (sel + 1) % 3; rep = 0; end
                else begin pos = sel; rep = base + 1; end
                if (!vmask[k-1]) begin
                    exp_cyc.push_back(c0 + k * pi);
                    exp_typ.push_back(sel);
                    pushed++;
                end
            end
        end
        for (int k = 1; k <= n; k++) begin
            if (k > 1) begin
                @(negedge clk);
                settings[1] = vmask[k-1];
                repeat (pi - 1) @(negedge clk);
            end else begin
                repeat (pi) @(negedge clk);
            end
        end
        repeat (2) @(negedge clk);
        run = 1'b0;
        settings[1] = 1'b0;
        repeat (pi + 4) @(negedge clk);
        check(n_seen - seen0 == pushed, req, "strobe count", n_seen - seen0, pushed);
        check(exp_cyc.size() == 0, req, "missing strobes", exp_cyc.size(), 0);
        exp_cyc.delete();
        exp_typ.delete();
    endtask

    function automatic int pack(input int a, input int b, input int c);
        return (a << 10) | (b << 5) | c;
    endfunction

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        check(trig == 1'b0, "R1", "trig in reset", trig, 0);
        settings = 8'h70; ratio = 15'(pack(1, 1, 1)); ivl = 10'd1;
        rst_n = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check(trig == 1'b0, "R1", "trig with run low", trig, 0);
        end
        // R4 mixed counts, field order and wrap
        run_case(2, pack(2, 1, 3), 8'h70, 8, 0, "R4");
        // R2 interval 0 acts as 1, and interval 3
        run_case(0, pack(1, 1, 1), 8'h70, 5, 0, "R2");
        run_case(3, pack(1, 2, 1), 8'h70, 4, 0, "R2");
        // R6 disabled kind and zero count skipped within the slot
        run_case(2, pack(1, 3, 2), 8'h50, 6, 0, "R6");
        run_case(2, pack(0, 2, 1), 8'h70, 5, 0, "R6");
        // R7 nothing eligible
        run_case(2, 0, 8'h70, 4, 0, "R7");
        run_case(2, pack(3, 3, 3), 8'h00, 4, 0, "R7");
        // R8 vetoed slots 2 and 5 still advance the sequence
        run_case(7, pack(1, 1, 1), 8'h70, 6, 32'b010010, "R8");
        // R9 stop in mid-group, then restart from the first pedestal slot
        run_case(3, pack(3, 1, 1), 8'h70, 2, 0, "R9");
        run_case(3, pack(3, 1, 1), 8'h70, 4, 0, "R9");
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule